// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block sits between a processor-side request port and an external 32-bit data bus. The devices on that bus may be 8, 16 or 32 bits wide, and each device reports its width on a 2-bit acknowledge code when it terminates a bus cycle. A request carries an address, a transfer size (byte, word or long) and, for writes, a right-justified operand. The controller issues as many bus cycles as the reported width and the address alignment require. For each cycle it drives the current address and places the remaining operand bytes on the byte lanes where a port of any width will find them. It then advances the address by the number of bytes the port took.

Byte order is big-endian: the operand's most significant byte belongs to the lowest address. The controller treats every cycle as a possible 8-, 16- or 32-bit transfer and waits for the acknowledge code to learn which one occurred. Because of this, a single request may run against a port whose width changes from cycle to cycle. On reads, the bytes returned on the active lanes are collected into an assembly register. The right-justified result is presented together with a one-cycle completion pulse.

Top module: `dyn_bus_sizer`

## Requirements
- R1: While reset is held, `bus_cyc` and `xfer_done` are 0 and `req_ready` is 1.
- R2: A request is taken when `req_valid` and `req_ready` are both 1. On the next clock `bus_cyc` is 1 and `bus_addr` equals the request address. A `req_valid` raised while a transfer is in progress has no effect: it starts no bus cycle after the current transfer completes.
- R3: Acknowledge code 2'b11 does not terminate the cycle. On the following clock `bus_cyc` stays 1, and `bus_addr` and `bus_wdata` keep their values.
- R4: Acknowledge code 2'b10 reports an 8-bit port. Exactly one byte moves per cycle, on `bus_wdata`/`bus_rdata` bits 31:24. A word therefore takes 2 cycles and a long takes 4.
- R5: Acknowledge code 2'b01 reports a 16-bit port. The byte at an even address uses bits 31:24 and the byte at an odd address uses bits 23:16. A word takes 1 cycle at an even address and 2 at an odd one. A long takes 2 cycles at an even address and 3 at an odd one.
- R6: Acknowledge code 2'b00 reports a 32-bit port. Address bits 1:0 equal to 0, 1, 2 or 3 use bits 31:24, 23:16, 15:8 or 7:0 respectively. A word takes 1 cycle except at offset 3, where it takes 2. A long takes 1 cycle only at offset 0 and 2 cycles at any other offset.
- R7: `req_size` 2'b00 is a byte, 2'b01 a word, and 2'b10 or 2'b11 a long. The operand is right-justified in `req_wdata` and in `rd_data`. Its most significant byte is transferred to or from the lowest address.
- R8: After each terminated cycle, `bus_addr` advances by exactly the number of bytes that cycle moved.
- R9: `xfer_done` is a single-cycle pulse in the cycle after the final terminating acknowledge. In that same cycle `bus_cyc` is 0.
- R10: On a read, each byte returned on its lane is placed in its operand position. `rd_data` holds the complete right-justified operand while `xfer_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | 32 | Byte address of the first operand byte |
| req_size | input | 2 | 00 byte, 01 word, 10/11 long |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Right-justified write operand |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_addr | output | 32 | Address of the current bus cycle |
| bus_write | output | 1 | Direction of the current bus cycle |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_ack | input | 2 | Termination and port width: 00 32-bit, 01 16-bit, 10 8-bit, 11 wait |
| bus_rdata | input | 32 | Read data from the port lanes |
| xfer_done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Right-justified read result, valid with `xfer_done` |

## Verification
The assertions assume that a responding port never accepts more bytes than its own width allows from the current address. They also assume that `bus_ack` and `bus_rdata` are meaningful only while `bus_cyc` is 1, and that the reported width does not change within a wait sequence.

The stimulus drives the acknowledge only during bus cycles, and a wait cycle is always followed by a terminating code for the same port. It sweeps every size, every start offset, every port width and both directions, with and without wait states. Lanes that the port does not use are filled with a junk pattern, so that a wrong lane selection shows up in the result.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

   typedef enum logic [1:0] {
      ACK_P32  = 2'b00,
      ACK_P16  = 2'b01,
      ACK_P8   = 2'b10,
      ACK_HOLD = 2'b11
   } ack_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_XFER = 1'b1
   } seq_e;

   // operand length in bytes for a size code; both upper codes mean long
   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      logic [2:0] n;
      case (code)
         2'b00:   n = 3'd1;
         2'b01:   n = 3'd2;
         default: n = 3'd4;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/dbs_step_calc.sv
module dbs_step_calc
   import dbs_pkg::*;
#(
   parameter int NLANE = 4,
   parameter int IDX_W = $clog2(NLANE),
   parameter int CNT_W = $clog2(NLANE + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic [1:0]       ack,
   input  logic [IDX_W-1:0] addr_lo,
   input  logic [CNT_W-1:0] rem,
   output logic             term,
   output logic [IDX_W-1:0] first_lane,
   output logic [CNT_W-1:0] step
);

   localparam int HALF = NLANE / 2;

   logic [CNT_W-1:0] room;

   always_comb begin
      term       = (ack_e'(ack) != ACK_HOLD);
      room       = CNT_W'(NLANE) - CNT_W'(addr_lo);
      first_lane = addr_lo;
      case (ack_e'(ack))
         ACK_P8: begin
            room       = CNT_W'(1);
            first_lane = '0;
         end
         ACK_P16: begin
            room       = CNT_W'(HALF) - CNT_W'(addr_lo[0]);
            first_lane = IDX_W'(addr_lo[0]);
         end
         default: begin
            room       = CNT_W'(NLANE) - CNT_W'(addr_lo);
            first_lane = addr_lo;
         end
      endcase
      if (!term)
         step = '0;
      else if (room < rem)
         step = room;
      else
         step = rem;
   end

   // R8: a terminated cycle always moves at least one byte and never more than remain
   a_r8_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && term) |-> (step != '0 && step <= rem));

endmodule

// File: rtl/dbs_lane_steer.sv
module dbs_lane_steer #(
   parameter int NLANE  = 4,
   parameter int BYTE_W = 8,
   parameter int IDX_W  = $clog2(NLANE),
   parameter int CNT_W  = $clog2(NLANE + 1),
   parameter int DW     = NLANE * BYTE_W
) (
   input  logic [DW-1:0]    opnd,
   input  logic [CNT_W-1:0] rem,
   input  logic [IDX_W-1:0] addr_lo,
   output logic [DW-1:0]    lanes
);

   // byte idx of the remaining operand (0 = next byte to send), zero if none left
   function automatic logic [BYTE_W-1:0] pick(input logic [DW-1:0] op,
                                              input logic [CNT_W-1:0] r,
                                              input int idx);
      logic [BYTE_W-1:0] b;
      b = '0;
      if (idx >= 0 && idx < int'(r))
         b = op[(NLANE-1-idx)*BYTE_W +: BYTE_W];
      return b;
   endfunction

   for (genvar L = 0; L < NLANE; L++) begin : g_lane
      localparam int HI = (NLANE - L) * BYTE_W - 1;
      if (L == 0) begin : g_top
         // every port width reads its first byte here unless offset says otherwise
         assign lanes[HI -: BYTE_W] = pick(opnd, rem, 0);
      end else if (L == 1) begin : g_second
         // half-width view: odd address puts the first byte here
         assign lanes[HI -: BYTE_W] = pick(opnd, rem, addr_lo[0] ? 0 : 1);
      end else begin : g_full
         assign lanes[HI -: BYTE_W] = (int'(addr_lo) <= L)
                                      ? pick(opnd, rem, L - int'(addr_lo))
                                      : '0;
      end
   end

endmodule

// File: rtl/dbs_read_gather.sv
module dbs_read_gather #(
   parameter int NLANE  = 4,
   parameter int BYTE_W = 8,
   parameter int IDX_W  = $clog2(NLANE),
   parameter int CNT_W  = $clog2(NLANE + 1),
   parameter int DW     = NLANE * BYTE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             cap,
   input  logic [IDX_W-1:0] first_lane,
   input  logic [CNT_W-1:0] step,
   input  logic [CNT_W-1:0] got,
   input  logic [DW-1:0]    rdata,
   output logic [DW-1:0]    assembled
);

   logic [DW-1:0] asm_q;
   logic [DW-1:0] asm_d;

   always_comb begin
      asm_d = asm_q;
      for (int k = 0; k < NLANE; k++) begin
         int lane;
         int pos;
         lane = int'(first_lane) + k;
         pos  = int'(got) + k;
         if (k < int'(step) && lane < NLANE && pos < NLANE)
            asm_d[(NLANE-1-pos)*BYTE_W +: BYTE_W] = rdata[(NLANE-1-lane)*BYTE_W +: BYTE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         asm_q <= '0;
      else if (clear)
         asm_q <= '0;
      else if (cap)
         asm_q <= asm_d;
   end

   assign assembled = asm_q;

   // R10: a capture never happens in the same cycle as a fresh start
   a_r10_no_clear_capture: assert property (@(posedge clk) disable iff (!rst_n)
      !(clear && cap));

endmodule

// File: rtl/dyn_bus_sizer.sv
module dyn_bus_sizer
   import dbs_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int NLANE   = 4,
   parameter int BYTE_W  = 8,
   parameter bit READ_EN = 1'b1,
   localparam int DW     = NLANE * BYTE_W,
   localparam int IDX_W  = $clog2(NLANE),
   localparam int CNT_W  = $clog2(NLANE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_write,
   input  logic [DW-1:0]     req_wdata,
   output logic              bus_cyc,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_write,
   output logic [DW-1:0]     bus_wdata,
   input  logic [1:0]        bus_ack,
   input  logic [DW-1:0]     bus_rdata,
   output logic              xfer_done,
   output logic [DW-1:0]     rd_data
);

   if (NLANE != 4) begin : g_bad_lanes
      $error("dyn_bus_sizer: NLANE must be 4");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("dyn_bus_sizer: BYTE_W must be positive");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("dyn_bus_sizer: ADDR_W too narrow");
   end

   seq_e              st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  rem_q;
   logic [CNT_W-1:0]  got_q;
   logic [CNT_W-1:0]  total_q;
   logic [DW-1:0]     opnd_q;
   logic              rw_q;
   logic              done_q;

   logic              accept;
   logic              busy;
   logic              term;
   logic              last;
   logic [IDX_W-1:0]  first_lane;
   logic [CNT_W-1:0]  step;
   logic [CNT_W-1:0]  req_nb;
   logic [DW-1:0]     steer;
   logic [DW-1:0]     assembled;

   assign busy   = (st_q == ST_XFER);
   assign accept = req_valid && (st_q == ST_IDLE);
   assign req_nb = CNT_W'(size_bytes(req_size));
   assign last   = busy && term && (step == rem_q);

   dbs_step_calc #(
      .NLANE (NLANE),
      .IDX_W (IDX_W),
      .CNT_W (CNT_W)
   ) u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy       (busy),
      .ack        (bus_ack),
      .addr_lo    (addr_q[IDX_W-1:0]),
      .rem        (rem_q),
      .term       (term),
      .first_lane (first_lane),
      .step       (step)
   );

   dbs_lane_steer #(
      .NLANE  (NLANE),
      .BYTE_W (BYTE_W),
      .IDX_W  (IDX_W),
      .CNT_W  (CNT_W),
      .DW     (DW)
   ) u_steer (
      .opnd    (opnd_q),
      .rem     (rem_q),
      .addr_lo (addr_q[IDX_W-1:0]),
      .lanes   (steer)
   );

   if (READ_EN) begin : g_read
      dbs_read_gather #(
         .NLANE  (NLANE),
         .BYTE_W (BYTE_W),
         .IDX_W  (IDX_W),
         .CNT_W  (CNT_W),
         .DW     (DW)
      ) u_gather (
         .clk        (clk),
         .rst_n      (rst_n),
         .clear      (accept),
         .cap        (busy && term && !rw_q),
         .first_lane (first_lane),
         .step       (step),
         .got        (got_q),
         .rdata      (bus_rdata),
         .assembled  (assembled)
      );
   end else begin : g_no_read
      assign assembled = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         addr_q  <= '0;
         rem_q   <= '0;
         got_q   <= '0;
         total_q <= '0;
         opnd_q  <= '0;
         rw_q    <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            st_q    <= ST_XFER;
            addr_q  <= req_addr;
            rem_q   <= req_nb;
            got_q   <= '0;
            total_q <= req_nb;
            opnd_q  <= req_wdata << (BYTE_W * (NLANE - int'(req_nb)));
            rw_q    <= req_write;
         end else if (busy && term) begin
            addr_q <= addr_q + ADDR_W'(step);
            rem_q  <= rem_q - step;
            got_q  <= got_q + step;
            opnd_q <= opnd_q << (BYTE_W * int'(step));
            if (last) begin
               st_q   <= ST_IDLE;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign req_ready = (st_q == ST_IDLE);
   assign bus_cyc   = busy;
   assign bus_addr  = addr_q;
   assign bus_write = rw_q;
   assign bus_wdata = (busy && rw_q) ? steer : '0;
   assign xfer_done = done_q;
   assign rd_data   = assembled >> (BYTE_W * (NLANE - int'(total_q)));

   // R2: a taken request opens a bus cycle at the requested address
   a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (bus_cyc && bus_addr == $past(req_addr)));

   // R3: the wait code keeps the cycle, its address and its data
   a_r3_hold_keeps_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && bus_ack == 2'b11) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_wdata)));

   // R8: an open cycle always has bytes left to move
   a_r8_bytes_left: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cyc |-> (rem_q != '0));

   // R9: completion follows a bus cycle and lasts one clock
   a_r9_done_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> ($past(bus_cyc) && !bus_cyc));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);

endmodule

// File: tb/dyn_bus_sizer_bench.sv
module dyn_bus_sizer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        bus_cyc;
   logic [31:0] bus_addr;
   logic        bus_write;
   logic [31:0] bus_wdata;
   logic [1:0]  bus_ack = 2'b11;
   logic [31:0] bus_rdata = '0;
   logic        xfer_done;
   logic [31:0] rd_data;

   int checks = 0;
   int fails  = 0;
   int tcount = 0;

   always #2 clk = ~clk;

   dyn_bus_sizer u_dyn_bus_sizer (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_addr  (req_addr),
      .req_size  (req_size),
      .req_write (req_write),
      .req_wdata (req_wdata),
      .bus_cyc   (bus_cyc),
      .bus_addr  (bus_addr),
      .bus_write (bus_write),
      .bus_wdata (bus_wdata),
      .bus_ack   (bus_ack),
      .bus_rdata (bus_rdata),
      .xfer_done (xfer_done),
      .rd_data   (rd_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // cycle counts taken directly from the port-width rules
   function automatic int exp_cycles(input logic [1:0] port, input int nb, input int off);
      int c;
      if (port == 2'b10)
         c = nb;
      else if (port == 2'b01)
         c = (nb == 1) ? 1 : (nb == 2) ? ((off % 2) ? 2 : 1) : ((off % 2) ? 3 : 2);
      else
         c = (nb == 1) ? 1 : (nb == 2) ? ((off == 3) ? 2 : 1) : ((off == 0) ? 1 : 2);
      return c;
   endfunction

   task automatic run_xfer(input logic [1:0] port, input int szc, input int off,
                           input bit wr, input bit waits, input bit poke);
      int nb, rem, n, room, lane0, cyc, ix;
      logic [31:0] base, a, op, expv, hold_a, hold_d, rd;
      logic [7:0]  mem [0:15];
      string preq;
      preq = (port == 2'b10) ? "R4" : (port == 2'b01) ? "R5" : "R6";
      nb   = (szc == 0) ? 1 : (szc == 1) ? 2 : 4;
      base = 32'h4000_0010;
      a    = base + 32'(off);
      op   = 32'hC3A5_9617 + 32'(tcount) * 32'h0001_1111;
      if (nb < 4) op = op & ((32'h1 << (8 * nb)) - 32'h1);
      tcount++;
      for (int i = 0; i < 16; i++)
         mem[i] = wr ? 8'h00 : 8'(8'h30 + 8'(i * 13));

      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      req_size  = 2'(szc);
      req_write = wr;
      req_wdata = op;
      @(negedge clk);
      req_valid = 1'b0;
      chk(bus_cyc == 1'b1 && bus_addr == a, "R2", "first cycle address", bus_addr, a);

      rem = nb;
      cyc = 0;
      while (rem > 0 && cyc < 8) begin
         if (!bus_cyc) begin
            chk(1'b0, "R9", "cycle ended early", 32'(cyc), 32'(rem));
            break;
         end
         if (waits) begin
            bus_ack = 2'b11;
            hold_a  = bus_addr;
            hold_d  = bus_wdata;
            @(negedge clk);
            chk(bus_cyc && bus_addr == hold_a, "R3", "address held in wait", bus_addr, hold_a);
            chk(bus_wdata == hold_d, "R3", "data held in wait", bus_wdata, hold_d);
         end
         chk(bus_addr == a, "R8", "cycle address", bus_addr, a);
         chk(bus_write == wr, "R2", "direction", 32'(bus_write), 32'(wr));
         room  = (port == 2'b10) ? 1 : (port == 2'b01) ? (2 - int'(a[0])) : (4 - int'(a[1:0]));
         lane0 = (port == 2'b10) ? 0 : (port == 2'b01) ? int'(a[0]) : int'(a[1:0]);
         n     = (room < rem) ? room : rem;
         ix    = int'(a - base);
         rd    = 32'hEEEE_EEEE;
         for (int k = 0; k < n; k++) begin
            if (wr)
               mem[ix + k] = bus_wdata[31 - 8 * (lane0 + k) -: 8];
            else
               rd[31 - 8 * (lane0 + k) -: 8] = mem[ix + k];
         end
         bus_ack   = port;
         bus_rdata = rd;
         if (poke && cyc == 0) begin
            req_valid = 1'b1;
            req_addr  = 32'h7000_0000;
         end
         @(negedge clk);
         req_valid = 1'b0;
         bus_ack   = 2'b11;
         bus_rdata = '0;
         rem = rem - n;
         a   = a + 32'(n);
         cyc++;
      end

      chk(xfer_done == 1'b1 && bus_cyc == 1'b0, "R9", "done pulse", {30'b0, bus_cyc, xfer_done}, 32'h1);
      chk(cyc == exp_cycles(port, nb, off), preq, "bus cycle count", 32'(cyc), 32'(exp_cycles(port, nb, off)));
      expv = '0;
      for (int i = 0; i < nb; i++) expv = (expv << 8) | 32'(mem[off + i]);
      if (wr)
         chk(expv == op, preq, "R7 bytes stored big-endian", expv, op);
      else
         chk(rd_data == expv, "R10", "assembled read", rd_data, expv);
      @(negedge clk);
      chk(xfer_done == 1'b0, "R9", "done lasts one cycle", 32'(xfer_done), 32'h0);
      chk(bus_cyc == 1'b0, "R2", "busy request ignored", 32'(bus_cyc), 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(bus_cyc == 1'b0, "R1", "reset bus_cyc", 32'(bus_cyc), 32'h0);
      chk(xfer_done == 1'b0, "R1", "reset done", 32'(xfer_done), 32'h0);
      chk(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 32'h1);
      rst_n = 1'b1;
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
         for (int s = 0; s < 3; s++) begin
            for (int o = 0; o < 4; o++) begin
               for (int w = 0; w < 2; w++) begin
                  for (int ws = 0; ws < 2; ws++) begin
                     logic [1:0] pc;
                     pc = (p == 0) ? 2'b10 : (p == 1) ? 2'b01 : 2'b00;
                     run_xfer(pc, s, o, w[0], ws[0], (o == 2 && ws == 0));
                  end
               end
            end
         end
      end
      // R7: size code 11 behaves as a long
      for (int o = 0; o < 4; o++) begin
         run_xfer(2'b00, 3, o, 1'b1, 1'b0, 1'b0);
         run_xfer(2'b01, 3, o, 1'b0, 1'b0, 1'b0);
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog R9: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule